// File: doc/BRIEF.md
# Parallel Display Write-Cycle Timing Generator

This block turns a stream of pixel or command words into write cycles on a parallel MIPI DBI display bus. It makes one write cycle per accepted word. A clock-enable divider derives a slower bit clock from the core clock. Each write cycle lasts a programmable number of bit-clock ticks, called the period. Within that period, the chip select and the write strobe each go active and inactive at tick indices that software sets. A bus-kind setting picks the physical signal that each of those settings controls. The three bus kinds are Type A with a fixed E level, Type A with a clocked E, and Type B (8080-style).

Before a word goes onto the bus, its bytes are reordered by an endian setting, and the colour bytes are swapped when BGR order is selected. The word then stays on the bus for the whole period. A ready/valid handshake takes the next word only after the current period has ended. If the timing settings are inconsistent, the block raises an error flag and refuses to start a cycle.

Top module: `dbi_write_gen`

## Requirements
- R1: One bit-clock tick lasts max(cfg_div,1) core clocks, so a write cycle keeps the block busy for period × max(cfg_div,1) core clocks. `in_ready` rises in the core clock that follows the end of the cycle.
- R2: `in_ready` is high only when no write cycle is running and `cfg_err` is low. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R3: In Type B (`cfg_bus_kind`=2), WRX is low for tick indices wr_on to wr_off-1 and CSX is low for tick indices cs_on to cs_off-1. E is low.
- R4: In Type A clocked E (`cfg_bus_kind`=1), E is high for tick indices wr_on to wr_off-1. CSX is low for the whole period and WRX stays high.
- R5: In Type A fixed E (`cfg_bus_kind`=0), E always equals `cfg_e_level`. CSX is low for tick indices cs_on to cs_off-1 and WRX stays high.
- R6: When no cycle is running, CSX and WRX are high. E is low, except in fixed-E mode, where R5 applies.
- R7: The formatted word appears on `dbi_data` from tick index 0 of its cycle. It stays unchanged until the next word is accepted.
- R8: Byte order codes: 0 and 3 keep the bytes as they are. 1 swaps the two bytes inside each 16-bit half. 2 reverses all bytes of the word (byte i takes input byte N-1-i).
- R9: With `cfg_bgr`=1, byte 0 and byte 2 of the reordered word trade places and the other bytes are unchanged. With `cfg_bgr`=0, the reordered word passes through.
- R10: `cfg_err` is high when any of these holds: wr_on ≥ wr_off, cs_on ≥ cs_off, wr_off ≥ period, cs_off ≥ period, or `cfg_bus_kind`=3. While it is high, no cycle starts, even if `in_valid` is held high.
- R11: All timing, divider, bus-kind and E-level settings are captured when a word is accepted. Changing them during a running cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_kind | input | 2 | 0 Type A fixed E, 1 Type A clocked E, 2 Type B, 3 invalid |
| cfg_div | input | DIV_W | Core clocks per bit-clock tick (0 acts as 1) |
| cfg_period | input | TICK_W | Ticks per write cycle |
| cfg_wr_on | input | TICK_W | Tick index where the write strobe / E goes active |
| cfg_wr_off | input | TICK_W | Tick index where the write strobe / E goes inactive |
| cfg_cs_on | input | TICK_W | Tick index where chip select goes active |
| cfg_cs_off | input | TICK_W | Tick index where chip select goes inactive |
| cfg_order | input | 2 | Byte order code |
| cfg_bgr | input | 1 | Swap colour bytes 0 and 2 |
| cfg_e_level | input | 1 | Constant E level in fixed-E mode |
| in_valid | input | 1 | Word offered |
| in_data | input | 8*NBYTES | Word to write |
| in_ready | output | 1 | Block can take a word |
| cfg_err | output | 1 | Timing settings are inconsistent |
| dbi_csx | output | 1 | Chip select, active low |
| dbi_wrx | output | 1 | Write strobe, active low |
| dbi_e | output | 1 | E signal (Type A) |
| dbi_data | output | 8*NBYTES | Bus data |

## Verification
The hardest situation to reach from the ports is a settings change that lands in the middle of a running cycle while a further word is already waiting. Here the captured values must win over the live inputs, and the waiting word must be held back until the old period has finished. The stimulus offers one word with a divider above one, then rewrites the period, the strobe indices and the divider a few clocks later, with `in_valid` still high for a follow-on word. The reference model builds each cycle's whole expected waveform at acceptance time, so any leak of the new settings into the old cycle shows up on the very clock it happens. The minimum legal period of two ticks and indices that sit on the period boundary are also exercised.

// File: rtl/dbi_wr_pkg.sv
package dbi_wr_pkg;

    localparam int TICK_W = 8;
    localparam int DIV_W  = 8;

    typedef enum logic [1:0] {
        BUS_A_FIXED   = 2'd0,
        BUS_A_CLOCKED = 2'd1,
        BUS_B         = 2'd2,
        BUS_BAD       = 2'd3
    } bus_kind_e;

    typedef enum logic [1:0] {
        ORD_NONE  = 2'd0,
        ORD_HALF  = 2'd1,
        ORD_WORD  = 2'd2,
        ORD_SPARE = 2'd3
    } byte_order_e;

    typedef struct packed {
        logic [TICK_W-1:0] period;
        logic [TICK_W-1:0] wr_on;
        logic [TICK_W-1:0] wr_off;
        logic [TICK_W-1:0] cs_on;
        logic [TICK_W-1:0] cs_off;
    } tick_plan_t;

    typedef struct packed {
        logic csx;
        logic wrx;
        logic e;
    } pin_set_t;

    function automatic logic plan_invalid(tick_plan_t p, logic [1:0] kind);
        return (kind == BUS_BAD)
            || (p.wr_on >= p.wr_off)
            || (p.cs_on >= p.cs_off)
            || (p.wr_off >= p.period)
            || (p.cs_off >= p.period);
    endfunction

    // Map the two timing windows onto physical pins for a given bus kind.
    function automatic pin_set_t pins_for(logic [1:0] kind, logic busy,
                                          logic cs_win, logic wr_win,
                                          logic e_lvl);
        pin_set_t p;
        p.csx = 1'b1;
        p.wrx = 1'b1;
        p.e   = 1'b0;
        case (bus_kind_e'(kind))
            BUS_A_FIXED: begin
                p.csx = ~(busy & cs_win);
                p.e   = e_lvl;
            end
            BUS_A_CLOCKED: begin
                p.csx = ~busy;
                p.e   = busy & wr_win;
            end
            BUS_B: begin
                p.csx = ~(busy & cs_win);
                p.wrx = ~(busy & wr_win);
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dbi_tick_div.sv
module dbi_tick_div
    import dbi_wr_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;

    assign last = (div == '0) ? '0 : div - W'(1);
    assign tick = run && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/dbi_word_fmt.sv
module dbi_word_fmt
    import dbi_wr_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES
) (
    input  logic [DW-1:0] din,
    input  logic [1:0]    order,
    input  logic          bgr,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] ord;

    for (genvar b = 0; b < NBYTES; b++) begin : g_ord
        localparam int HB = ((b ^ 1) < NBYTES) ? (b ^ 1) : b;
        localparam int WB = NBYTES - 1 - b;
        always_comb begin
            case (byte_order_e'(order))
                ORD_HALF: ord[b*8 +: 8] = din[HB*8 +: 8];
                ORD_WORD: ord[b*8 +: 8] = din[WB*8 +: 8];
                default:  ord[b*8 +: 8] = din[b*8 +: 8];
            endcase
        end
    end

    if (NBYTES >= 3) begin : g_swz
        for (genvar b = 0; b < NBYTES; b++) begin : g_b
            localparam int SB = (b == 0) ? 2 : ((b == 2) ? 0 : b);
            assign dout[b*8 +: 8] = bgr ? ord[SB*8 +: 8] : ord[b*8 +: 8];
        end
    end else begin : g_noswz
        assign dout = ord;
    end
endmodule

// File: rtl/dbi_cycle_seq.sv
module dbi_cycle_seq
    import dbi_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       tick,
    input  tick_plan_t plan,
    output logic       busy,
    output logic       cs_win,
    output logic       wr_win
);
    logic [TICK_W-1:0] idx_q;
    logic              busy_q;
    logic              at_end;

    assign at_end = (idx_q == plan.period - TICK_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && tick) begin
            if (at_end) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + TICK_W'(1);
            end
        end
    end

    assign busy   = busy_q;
    assign cs_win = busy_q && (idx_q >= plan.cs_on) && (idx_q < plan.cs_off);
    assign wr_win = busy_q && (idx_q >= plan.wr_on) && (idx_q < plan.wr_off);
endmodule

// File: rtl/dbi_write_gen.sv
module dbi_write_gen
    import dbi_wr_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int DW = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_bus_kind,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [TICK_W-1:0] cfg_period,
    input  logic [TICK_W-1:0] cfg_wr_on,
    input  logic [TICK_W-1:0] cfg_wr_off,
    input  logic [TICK_W-1:0] cfg_cs_on,
    input  logic [TICK_W-1:0] cfg_cs_off,
    input  logic [1:0]        cfg_order,
    input  logic              cfg_bgr,
    input  logic              cfg_e_level,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    output logic              in_ready,
    output logic              cfg_err,
    output logic              dbi_csx,
    output logic              dbi_wrx,
    output logic              dbi_e,
    output logic [DW-1:0]     dbi_data
);
    tick_plan_t       live_plan;
    tick_plan_t       lat_plan;
    logic [1:0]       lat_kind;
    logic [DIV_W-1:0] lat_div;
    logic             lat_elev;
    logic [DW-1:0]    data_q;
    logic [DW-1:0]    fmt_word;
    logic             busy;
    logic             tick;
    logic             cs_win;
    logic             wr_win;
    logic             accept;
    pin_set_t         pins;

    assign live_plan = '{period: cfg_period, wr_on: cfg_wr_on, wr_off: cfg_wr_off,
                         cs_on: cfg_cs_on, cs_off: cfg_cs_off};
    assign cfg_err   = plan_invalid(live_plan, cfg_bus_kind);
    assign in_ready  = !busy && !cfg_err;
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_plan <= '0;
            lat_kind <= BUS_A_FIXED;
            lat_div  <= '0;
            lat_elev <= 1'b0;
            data_q   <= '0;
        end else if (accept) begin
            lat_plan <= live_plan;
            lat_kind <= cfg_bus_kind;
            lat_div  <= cfg_div;
            lat_elev <= cfg_e_level;
            data_q   <= fmt_word;
        end
    end

    dbi_word_fmt #(.NBYTES(NBYTES)) u_fmt (
        .din   (in_data),
        .order (cfg_order),
        .bgr   (cfg_bgr),
        .dout  (fmt_word)
    );

    dbi_tick_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (busy),
        .div   (lat_div),
        .tick  (tick)
    );

    dbi_cycle_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .tick   (tick),
        .plan   (lat_plan),
        .busy   (busy),
        .cs_win (cs_win),
        .wr_win (wr_win)
    );

    // While idle, the live bus kind decides the resting E level.
    assign pins = busy ? pins_for(lat_kind, 1'b1, cs_win, wr_win, lat_elev)
                       : pins_for(cfg_bus_kind, 1'b0, 1'b0, 1'b0, cfg_e_level);

    assign dbi_csx  = pins.csx;
    assign dbi_wrx  = pins.wrx;
    assign dbi_e    = pins.e;
    assign dbi_data = data_q;
endmodule

// File: rtl/dbi_write_gen_chk.sv
module dbi_write_gen_chk
    import dbi_wr_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             in_ready,
    input logic             cfg_err,
    input logic             dbi_csx,
    input logic             dbi_wrx,
    input logic             dbi_e,
    input logic [DW-1:0]    dbi_data,
    input logic [1:0]       lat_kind,
    input logic             lat_elev,
    input tick_plan_t       lat_plan
);
    // R6
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dbi_csx && dbi_wrx));

    // R2
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!cfg_err && !busy));

    // R10
    err_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !busy) |=> !busy);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dbi_data));

    // R3
    wrx_typeb_chk: assert property (@(posedge clk) disable iff (rst)
        !dbi_wrx |-> (busy && lat_kind == BUS_B));

    // R5
    e_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && lat_kind == BUS_A_FIXED) |-> (dbi_e == lat_elev));

    // R4
    csx_clocked_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && lat_kind == BUS_A_CLOCKED) |-> !dbi_csx);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(lat_plan));
endmodule

bind dbi_write_gen dbi_write_gen_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .in_ready (in_ready),
    .cfg_err  (cfg_err),
    .dbi_csx  (dbi_csx),
    .dbi_wrx  (dbi_wrx),
    .dbi_e    (dbi_e),
    .dbi_data (dbi_data),
    .lat_kind (lat_kind),
    .lat_elev (lat_elev),
    .lat_plan (lat_plan)
);

// File: tb/dbi_write_gen_test.sv
`timescale 1ns/1ps
module dbi_write_gen_test;

    localparam int NB = 4;
    localparam int DW = 8 * NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_bus_kind = 2'd2;
    logic [7:0]    cfg_div = 8'd1;
    logic [7:0]    cfg_period = 8'd14;
    logic [7:0]    cfg_wr_on = 8'd6;
    logic [7:0]    cfg_wr_off = 8'd13;
    logic [7:0]    cfg_cs_on = 8'd1;
    logic [7:0]    cfg_cs_off = 8'd4;
    logic [1:0]    cfg_order = 2'd0;
    logic          cfg_bgr = 1'b0;
    logic          cfg_e_level = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, cfg_err, dbi_csx, dbi_wrx, dbi_e;
    logic [DW-1:0] dbi_data;

    always #4 clk = ~clk;

    dbi_write_gen uut (
        .clk(clk), .rst(rst), .cfg_bus_kind(cfg_bus_kind), .cfg_div(cfg_div),
        .cfg_period(cfg_period), .cfg_wr_on(cfg_wr_on), .cfg_wr_off(cfg_wr_off),
        .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off), .cfg_order(cfg_order),
        .cfg_bgr(cfg_bgr), .cfg_e_level(cfg_e_level), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .cfg_err(cfg_err),
        .dbi_csx(dbi_csx), .dbi_wrx(dbi_wrx), .dbi_e(dbi_e), .dbi_data(dbi_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit mid_change = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit csx; bit wrx; bit e; logic [DW-1:0] data; int kind;
    } exp_t;
    exp_t exp_q[$];
    logic [DW-1:0] last_data = '0;
    bit model_idle = 1'b0;

    function automatic bit cfg_bad();
        return (cfg_bus_kind == 2'd3) || (cfg_wr_on >= cfg_wr_off) ||
               (cfg_cs_on >= cfg_cs_off) || (cfg_wr_off >= cfg_period) ||
               (cfg_cs_off >= cfg_period);
    endfunction

    function automatic logic [DW-1:0] ref_fmt(logic [DW-1:0] w, int ord, bit bgr);
        logic [7:0] src [4];
        logic [7:0] dst [4];
        logic [7:0] t;
        for (int i = 0; i < 4; i++) src[i] = w[8*i +: 8];
        for (int i = 0; i < 4; i++) begin
            if (ord == 1)      dst[i] = src[i ^ 1];
            else if (ord == 2) dst[i] = src[3 - i];
            else               dst[i] = src[i];
        end
        if (bgr) begin t = dst[0]; dst[0] = dst[2]; dst[2] = t; end
        return {dst[3], dst[2], dst[1], dst[0]};
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: on acceptance, lay out the whole expected waveform.
    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete();
            last_data = '0;
            model_idle = 1'b0;
        end else if (model_idle && in_valid && !cfg_bad()) begin
            int d;
            exp_t x;
            d = (cfg_div == 0) ? 1 : int'(cfg_div);
            x.data = ref_fmt(in_data, int'(cfg_order), cfg_bgr);
            x.kind = int'(cfg_bus_kind);
            last_data = x.data;
            for (int i = 0; i < int'(cfg_period); i++) begin
                bit cs_a, wr_a;
                cs_a = (i >= int'(cfg_cs_on)) && (i < int'(cfg_cs_off));
                wr_a = (i >= int'(cfg_wr_on)) && (i < int'(cfg_wr_off));
                case (cfg_bus_kind)
                    2'd0: begin x.csx = !cs_a; x.wrx = 1; x.e = cfg_e_level; end
                    2'd1: begin x.csx = 0;     x.wrx = 1; x.e = wr_a; end
                    default: begin x.csx = !cs_a; x.wrx = !wr_a; x.e = 0; end
                endcase
                for (int j = 0; j < d; j++) exp_q.push_back(x);
            end
            model_idle = 1'b0;
        end
    end

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            string tag;
            check(cfg_err == cfg_bad(), "R10 cfg_err", DW'(cfg_err), DW'(cfg_bad()));
            if (exp_q.size() == 0) begin
                bit e_idle;
                e_idle = (cfg_bus_kind == 2'd0) ? cfg_e_level : 1'b0;
                check(in_ready == !cfg_bad(), "R1 R2 ready when idle",
                      DW'(in_ready), DW'(!cfg_bad()));
                check(dbi_csx && dbi_wrx && dbi_e == e_idle, "R6 idle pins",
                      DW'({dbi_csx, dbi_wrx, dbi_e}), DW'({2'b11, e_idle}));
                check(dbi_data == last_data, "R7 data held while idle", dbi_data, last_data);
                model_idle = 1'b1;
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                tag = (x.kind == 0) ? "R5" : (x.kind == 1) ? "R4" : "R3";
                if (mid_change) tag = {tag, " R11"};
                check(in_ready == 1'b0, "R1 R2 busy ready", DW'(in_ready), '0);
                check(dbi_csx == x.csx && dbi_wrx == x.wrx && dbi_e == x.e,
                      {tag, " pins"}, DW'({dbi_csx, dbi_wrx, dbi_e}),
                      DW'({x.csx, x.wrx, x.e}));
                check(dbi_data == x.data, "R7 R8 R9 bus data", dbi_data, x.data);
            end
        end
    end

    task automatic send(logic [DW-1:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic set_plan(int p, int won, int woff, int con, int coff);
        cfg_period = 8'(p); cfg_wr_on = 8'(won); cfg_wr_off = 8'(woff);
        cfg_cs_on = 8'(con); cfg_cs_off = 8'(coff);
    endtask

    task automatic hold_valid_bad(int n);
        in_valid = 1'b1;
        in_data  = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // Reset state (R6, R7)
        check(dbi_csx && dbi_wrx && !dbi_e && dbi_data == '0, "R6 R7 reset state",
              DW'({dbi_csx, dbi_wrx, dbi_e}), DW'(3'b110));

        // Type B, example timing, all byte orders
        send(32'h1122_3344);
        cfg_order = 2'd1; send(32'hA1B2_C3D4);
        cfg_order = 2'd2; send(32'h0102_0304);
        cfg_order = 2'd3; send(32'hCAFE_F00D);
        cfg_order = 2'd0; cfg_bgr = 1'b1; send(32'h00AA_BBCC);
        cfg_order = 2'd2; send(32'h5566_7788);
        cfg_bgr = 1'b0; cfg_order = 2'd0;

        // Divider above one and divider zero (R1)
        cfg_div = 8'd3; send(32'h1357_9BDF);
        cfg_div = 8'd0; send(32'h2468_ACE0);
        cfg_div = 8'd1;

        // Type A clocked E (R4)
        wait_idle();
        cfg_bus_kind = 2'd1; send(32'h0F0F_0F0F);
        cfg_div = 8'd2; send(32'hF0F0_F0F0);
        cfg_div = 8'd1;

        // Type A fixed E, both levels (R5)
        wait_idle();
        cfg_bus_kind = 2'd0; cfg_e_level = 1'b1; send(32'h7777_8888);
        wait_idle();
        cfg_e_level = 1'b0; send(32'h9999_AAAA);

        // Smallest legal period (R3)
        wait_idle();
        cfg_bus_kind = 2'd2; set_plan(2, 0, 1, 0, 1); send(32'h1234_5678);
        set_plan(3, 1, 2, 0, 2); send(32'h8765_4321);

        // Bad settings: held valid must not start a cycle (R10)
        wait_idle();
        set_plan(14, 6, 6, 1, 4);   hold_valid_bad(6);
        set_plan(14, 6, 14, 1, 4);  hold_valid_bad(6);
        set_plan(14, 6, 13, 1, 14); hold_valid_bad(6);
        set_plan(14, 6, 13, 5, 4);  hold_valid_bad(6);
        set_plan(14, 6, 13, 1, 4); cfg_bus_kind = 2'd3; hold_valid_bad(6);
        cfg_bus_kind = 2'd2;

        // Back-to-back with valid held high
        in_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            in_data = 32'h1000_0000 * k + 32'h0000_0101;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;

        // Settings change in mid-cycle with a waiting word (R11)
        wait_idle();
        cfg_div = 8'd2;
        in_data = 32'hABCD_EF01; in_valid = 1'b1;
        @(negedge clk);
        in_data = 32'h0203_0405;
        mid_change = 1'b1;
        repeat (3) @(negedge clk);
        set_plan(9, 2, 7, 1, 8); cfg_div = 8'd1; cfg_bgr = 1'b1;
        while (!in_ready) @(negedge clk);
        mid_change = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;

        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule